// File: doc/BRIEF.md
# Safety Supervisor Diagnostic State Controller

This block is the mode sequencer of a safety power-management device. After power-up it sits in a reset state until the reset-extension interval ends. It then enters a diagnostic state if the device error counter is within the safe-lock limit, or parks in a safe state if it is not. The diagnostic state is where host software runs its self-tests and changes configuration. The state has a bounded dwell time. If it runs out, the device drops to the safe state and records a sticky timeout flag. The host can mask that dwell limit while developing software. With the limit masked, a watchdog-failure escape back to reset stays armed. The host can also shut the device off by clearing the wake latch, or promote it to the normal operating state.

Decoded host commands reach the block as single-cycle pulses. The watchdog failure events come in the same way, and threshold values arrive as levels. No data streams through the block, so it has no valid/ready handshake. Every input and output is a plain control or status pin, sampled or updated on the rising clock edge. The block also gates configuration register writes and tracks a small saturating watchdog failure counter. Each watchdog configuration update issues a restart pulse to the watchdog sequencer.

Top module: `diag_supervisor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `state_o` reads RESET. State codes are RESET=0, DIAGNOSTIC=1, SAFE=2, OFF=3, ACTIVE=4. In that same window, `diag_to_o`, `diag_mask_o`, `cfg_wr_en_o`, `wd_restart_o` and `wd_fail_cnt_o` read 0, and `wd_rst_en_o` reads 1.
- R2: In RESET, a `rext_done_i` pulse moves the state to DIAGNOSTIC on the next edge when `dev_err_cnt_i <= safe_lock_th_i`, and to SAFE otherwise.
- R3: In SAFE, `cmd_safe_exit_i` moves the state to DIAGNOSTIC on the next edge. In every other state that command has no effect.
- R4: Without the mask, DIAGNOSTIC lasts exactly `DIAG_TO_CYC` cycles and is then left for SAFE, and `diag_to_o` rises. The dwell count restarts from zero on every entry. `diag_to_o` stays 1 until reset.
- R5: `cmd_clr_wake_i` in DIAGNOSTIC or ACTIVE moves the state to OFF. OFF is kept until reset, whatever the inputs.
- R6: `cmd_mask_exit_i` in DIAGNOSTIC sets `diag_mask_o`, which stays set until reset. While it is set, the dwell limit never forces an exit.
- R7: In DIAGNOSTIC with the mask set, the state moves to RESET when `wd_rst_en_o` is 1 and `wd_fail_cnt_o >= wd_rst_th_i`. Entering RESET clears the fail count. With `wd_rst_en_o` at 0 there is no such escape.
- R8: `cfg_wr_en_o` is 1 only when `cfg_wr_req_i` is high, the state is DIAGNOSTIC, and `cmd_clr_lock_i` was seen during the current DIAGNOSTIC stay. Every exit from DIAGNOSTIC restores the lock.
- R9: A `wd_cfg_upd_i` pulse in DIAGNOSTIC loads `wd_rst_en_o` from `wd_cfg_rst_en_i`, adds one to the fail count, and raises `wd_restart_o` for one cycle. Outside DIAGNOSTIC it is ignored. Each `wd_fail_evt_i` pulse also adds one. The count saturates at 15.
- R10: Same-cycle events in DIAGNOSTIC are resolved in this order: wake-latch clear, then watchdog escape, then dwell timeout, then `cmd_go_active_i`.
- R11: `cmd_go_active_i` in DIAGNOSTIC moves the state to ACTIVE, where the dwell limit no longer applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rext_done_i | input | 1 | Reset-extension interval finished (pulse) |
| dev_err_cnt_i | input | ERR_W | Device error counter value |
| safe_lock_th_i | input | ERR_W | Safe-lock threshold |
| cmd_safe_exit_i | input | 1 | Host command: leave SAFE |
| cmd_clr_wake_i | input | 1 | Host command: clear wake latch |
| cmd_clr_lock_i | input | 1 | Host command: remove configuration write lock |
| cmd_mask_exit_i | input | 1 | Host command: mask the diagnostic dwell limit |
| cmd_go_active_i | input | 1 | Host command: enter normal operation |
| wd_cfg_upd_i | input | 1 | Watchdog configuration update (pulse) |
| wd_cfg_rst_en_i | input | 1 | Reset-enable value carried by the update |
| wd_fail_evt_i | input | 1 | Watchdog failure event (pulse) |
| wd_rst_th_i | input | FC_W | Watchdog reset threshold |
| cfg_wr_req_i | input | 1 | Configuration register write request |
| state_o | output | 3 | Current state code |
| diag_to_o | output | 1 | Sticky diagnostic-timeout status |
| diag_mask_o | output | 1 | Dwell-limit mask bit |
| cfg_wr_en_o | output | 1 | Configuration write accepted |
| wd_rst_en_o | output | 1 | Watchdog reset-enable bit |
| wd_fail_cnt_o | output | FC_W | Saturating watchdog fail count |
| wd_restart_o | output | 1 | Watchdog sequence restart pulse |

## Verification
The assertions take for granted that every command input is a pulse or level that is already synchronous to `clk`. They also assume `wd_rst_th_i` and `safe_lock_th_i` are held steady while the controller depends on them. The stimulus changes every input only on the falling edge. It holds each command for exactly one cycle and keeps the thresholds constant within each scenario. The saturation and monotonic-count properties therefore see only the increments that the requirements allow. Several scenarios drive more than one event into the same cycle on purpose, to exercise the priority order.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_DIAG   = 3'd1,
    ST_SAFE   = 3'd2,
    ST_OFF    = 3'd3,
    ST_ACTIVE = 3'd4
  } sup_state_e;
endpackage

// File: rtl/sdc_dwell_timer.sv
// Counts cycles spent in the diagnostic state; flags the last allowed cycle.
module sdc_dwell_timer #(
  parameter int TO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_diag_i,
  output logic expire_o
);
  localparam int CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!in_diag_i) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = in_diag_i && (cnt_q == LIM);

  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R4
  AST_DWELL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_diag_i) |-> (cnt_q == '0)); // R4
endmodule

// File: rtl/sdc_wd_tracker.sv
// Watchdog reset-enable bit, saturating fail counter and restart pulse.
module sdc_wd_tracker #(
  parameter int FC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_diag_i,
  input  logic            cfg_upd_i,
  input  logic            cfg_rst_en_i,
  input  logic            fail_evt_i,
  input  logic            clear_i,
  input  logic [FC_W-1:0] rst_th_i,
  output logic            rst_en_o,
  output logic [FC_W-1:0] fail_cnt_o,
  output logic            restart_o,
  output logic            escape_req_o
);
  localparam logic [FC_W-1:0] CNT_MAX = '1;

  logic            cfg_take;
  logic [1:0]      inc;
  logic [FC_W:0]   sum;
  logic [FC_W-1:0] cnt_next;
  logic [FC_W-1:0] cnt_q;
  logic            en_q;
  logic            rs_q;

  assign cfg_take = cfg_upd_i && in_diag_i;
  assign inc      = {1'b0, cfg_take} + {1'b0, fail_evt_i};
  assign sum      = {1'b0, cnt_q} + (FC_W+1)'(inc);
  assign cnt_next = sum[FC_W] ? CNT_MAX : sum[FC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
      rs_q  <= 1'b0;
    end else begin
      rs_q <= cfg_take;
      if (cfg_take) en_q <= cfg_rst_en_i;
      if (clear_i) cnt_q <= '0;
      else         cnt_q <= cnt_next;
    end
  end

  assign rst_en_o     = en_q;
  assign fail_cnt_o   = cnt_q;
  assign restart_o    = rs_q;
  assign escape_req_o = en_q && (cnt_q >= rst_th_i);

  AST_FC_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (cnt_q >= $past(cnt_q))); // R9
  AST_RESTART_IN_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> $past(in_diag_i)); // R9
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_diag_i |=> $stable(en_q)); // R9
endmodule

// File: rtl/sdc_cfg_gate.sv
// Configuration write lock: opened by command inside DIAGNOSTIC, closed on exit.
module sdc_cfg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_diag_i,
  input  logic in_diag_next_i,
  input  logic unlock_cmd_i,
  input  logic wr_req_i,
  output logic wr_en_o
);
  logic unlocked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) unlocked_q <= 1'b0;
    else        unlocked_q <= in_diag_next_i &&
                              (unlocked_q || (in_diag_i && unlock_cmd_i));
  end

  assign wr_en_o = wr_req_i && in_diag_i && unlocked_q;

  AST_LOCK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q |-> in_diag_i); // R8
  AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(unlock_cmd_i)); // R8
endmodule

// File: rtl/diag_supervisor.sv
module diag_supervisor
  import sdc_pkg::*;
#(
  parameter int DIAG_TO_CYC = 64,
  parameter int ERR_W       = 4,
  parameter int FC_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rext_done_i,
  input  logic [ERR_W-1:0] dev_err_cnt_i,
  input  logic [ERR_W-1:0] safe_lock_th_i,
  input  logic             cmd_safe_exit_i,
  input  logic             cmd_clr_wake_i,
  input  logic             cmd_clr_lock_i,
  input  logic             cmd_mask_exit_i,
  input  logic             cmd_go_active_i,
  input  logic             wd_cfg_upd_i,
  input  logic             wd_cfg_rst_en_i,
  input  logic             wd_fail_evt_i,
  input  logic [FC_W-1:0]  wd_rst_th_i,
  input  logic             cfg_wr_req_i,
  output logic [2:0]       state_o,
  output logic             diag_to_o,
  output logic             diag_mask_o,
  output logic             cfg_wr_en_o,
  output logic             wd_rst_en_o,
  output logic [FC_W-1:0]  wd_fail_cnt_o,
  output logic             wd_restart_o
);
  sup_state_e state_q, state_d;
  logic mask_q, to_q;
  logic in_diag, in_diag_next;
  logic expire, escape_req, to_fire, enter_reset;

  assign in_diag      = (state_q == ST_DIAG);
  assign in_diag_next = (state_d == ST_DIAG);

  sdc_dwell_timer #(.TO_CYC(DIAG_TO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .in_diag_i(in_diag), .expire_o(expire)
  );

  sdc_wd_tracker #(.FC_W(FC_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .in_diag_i(in_diag),
    .cfg_upd_i(wd_cfg_upd_i), .cfg_rst_en_i(wd_cfg_rst_en_i),
    .fail_evt_i(wd_fail_evt_i), .clear_i(enter_reset),
    .rst_th_i(wd_rst_th_i), .rst_en_o(wd_rst_en_o),
    .fail_cnt_o(wd_fail_cnt_o), .restart_o(wd_restart_o),
    .escape_req_o(escape_req)
  );

  sdc_cfg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .in_diag_i(in_diag),
    .in_diag_next_i(in_diag_next), .unlock_cmd_i(cmd_clr_lock_i),
    .wr_req_i(cfg_wr_req_i), .wr_en_o(cfg_wr_en_o)
  );

  // timeout exit only when nothing of higher priority claims the cycle
  assign to_fire = in_diag && !mask_q && expire && !cmd_clr_wake_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET: if (rext_done_i)
                  state_d = (dev_err_cnt_i <= safe_lock_th_i) ? ST_DIAG : ST_SAFE;
      ST_DIAG: begin
        if (cmd_clr_wake_i)            state_d = ST_OFF;
        else if (mask_q && escape_req) state_d = ST_RESET;
        else if (to_fire)              state_d = ST_SAFE;
        else if (cmd_go_active_i)      state_d = ST_ACTIVE;
      end
      ST_SAFE:   if (cmd_safe_exit_i) state_d = ST_DIAG;
      ST_OFF:    state_d = ST_OFF;
      ST_ACTIVE: if (cmd_clr_wake_i)  state_d = ST_OFF;
      default:   state_d = ST_RESET;
    endcase
  end

  assign enter_reset = (state_d == ST_RESET) && (state_q != ST_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      mask_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (in_diag && cmd_mask_exit_i) mask_q <= 1'b1;
      if (to_fire) to_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign diag_to_o   = to_q;
  assign diag_mask_o = mask_q;

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> (state_q == ST_OFF)); // R5
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |=> to_q); // R4
  AST_MASK_NO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_diag && mask_q) |=> (state_q != ST_SAFE)); // R6
  AST_SAFE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SAFE) && !cmd_safe_exit_i) |=> (state_q == ST_SAFE)); // R3
  AST_WAKE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_diag && cmd_clr_wake_i) |=> (state_q == ST_OFF)); // R10
  AST_RESET_CLEARS_FC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_diag && $past(in_diag) && (state_d == ST_RESET)) |=> (wd_fail_cnt_o == '0)); // R7
endmodule

// File: tb/diag_supervisor_test.sv
`timescale 1ns/1ps
module diag_supervisor_test;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rext_done = 0, safe_exit = 0, clr_wake = 0, clr_lock = 0;
  logic mask_cmd = 0, go_active = 0, wd_upd = 0, wd_upd_en = 0, fail_evt = 0, wr_req = 0;
  logic [3:0] err_cnt = 4'd1, lock_th = 4'd3, wd_th = 4'd3;
  logic [2:0] state;
  logic diag_to, diag_mask, wr_en, rst_en, restart;
  logic [3:0] fail_cnt;

  int nvec = 0;
  int nfail = 0;

  always #4 clk = ~clk; // 125 MHz

  diag_supervisor #(.DIAG_TO_CYC(TO), .ERR_W(4), .FC_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .rext_done_i(rext_done),
    .dev_err_cnt_i(err_cnt), .safe_lock_th_i(lock_th),
    .cmd_safe_exit_i(safe_exit), .cmd_clr_wake_i(clr_wake),
    .cmd_clr_lock_i(clr_lock), .cmd_mask_exit_i(mask_cmd),
    .cmd_go_active_i(go_active), .wd_cfg_upd_i(wd_upd),
    .wd_cfg_rst_en_i(wd_upd_en), .wd_fail_evt_i(fail_evt),
    .wd_rst_th_i(wd_th), .cfg_wr_req_i(wr_req),
    .state_o(state), .diag_to_o(diag_to), .diag_mask_o(diag_mask),
    .cfg_wr_en_o(wr_en), .wd_rst_en_o(rst_en),
    .wd_fail_cnt_o(fail_cnt), .wd_restart_o(restart)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    rext_done = 0; safe_exit = 0; clr_wake = 0; clr_lock = 0;
    mask_cmd = 0; go_active = 0; wd_upd = 0; fail_evt = 0; wr_req = 0;
  endtask

  task automatic do_reset();
    idle_in();
    err_cnt = 4'd1; lock_th = 4'd3; wd_th = 4'd3; wd_upd_en = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  task automatic enter_diag();
    rext_done = 1; tick(); rext_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", state, 0);
    chk("R1 diag_to", diag_to, 0);
    chk("R1 mask", diag_mask, 0);
    chk("R1 rst_en", rst_en, 1);
    chk("R1 fail_cnt", fail_cnt, 0);
    chk("R1 restart", restart, 0);
    wr_req = 1; #1; chk("R1 wr_en", wr_en, 0); wr_req = 0;
  endtask

  task automatic t_timeout();
    do_reset();
    safe_exit = 1; tick(); safe_exit = 0;
    chk("R3 safe_exit ignored in RESET", state, 0);
    err_cnt = 4'd3; enter_diag();
    chk("R2 err==th enters DIAG", state, 1);
    repeat (TO-1) tick();
    chk("R4 still DIAG at last cycle", state, 1);
    chk("R4 flag low before expiry", diag_to, 0);
    tick();
    chk("R4 timeout to SAFE", state, 2);
    chk("R4 flag set", diag_to, 1);
    wd_upd = 1; wd_upd_en = 0; tick(); wd_upd = 0;
    chk("R9 upd ignored in SAFE cnt", fail_cnt, 0);
    chk("R9 upd ignored in SAFE en", rst_en, 1);
    chk("R9 no restart in SAFE", restart, 0);
    safe_exit = 1; tick(); safe_exit = 0;
    chk("R3 SAFE exit to DIAG", state, 1);
    chk("R4 flag sticky", diag_to, 1);
    repeat (TO-1) tick();
    chk("R4 timer restarted", state, 1);
    tick();
    chk("R4 second timeout", state, 2);
  endtask

  task automatic t_lock_safe();
    do_reset();
    err_cnt = 4'd4; enter_diag();
    chk("R2 err>th goes SAFE", state, 2);
  endtask

  task automatic t_wake();
    do_reset(); enter_diag();
    clr_wake = 1; tick(); clr_wake = 0;
    chk("R5 wake clear to OFF", state, 3);
    safe_exit = 1; rext_done = 1; go_active = 1; tick(); idle_in();
    repeat (30) tick();
    chk("R5 OFF held", state, 3);
    chk("R5 no timeout flag", diag_to, 0);
  endtask

  task automatic t_mask_escape();
    do_reset(); enter_diag();
    mask_cmd = 1; tick(); mask_cmd = 0;
    chk("R6 mask set", diag_mask, 1);
    repeat (TO+10) tick();
    chk("R6 masked stays DIAG", state, 1);
    chk("R6 no flag", diag_to, 0);
    fail_evt = 1; tick(); tick(); fail_evt = 0;
    chk("R7 below threshold stays", state, 1);
    chk("R9 fail count", fail_cnt, 2);
    fail_evt = 1; tick(); fail_evt = 0;
    chk("R7 count at threshold", fail_cnt, 3);
    chk("R7 one cycle before escape", state, 1);
    tick();
    chk("R7 escape to RESET", state, 0);
    chk("R7 count cleared", fail_cnt, 0);
    chk("R6 mask kept", diag_mask, 1);
  endtask

  task automatic t_no_escape();
    do_reset(); enter_diag();
    wd_upd = 1; wd_upd_en = 0; tick(); wd_upd = 0;
    chk("R9 rst_en loaded", rst_en, 0);
    chk("R9 upd increments", fail_cnt, 1);
    chk("R9 restart pulse", restart, 1);
    tick();
    chk("R9 restart one cycle", restart, 0);
    mask_cmd = 1; tick(); mask_cmd = 0;
    fail_evt = 1; repeat (20) tick(); fail_evt = 0;
    chk("R9 saturate at 15", fail_cnt, 15);
    chk("R7 no escape when disabled", state, 1);
  endtask

  task automatic t_cfg();
    do_reset(); enter_diag();
    wr_req = 1; #1;
    chk("R8 locked in DIAG", wr_en, 0);
    wr_req = 0;
    clr_lock = 1; tick(); clr_lock = 0;
    wr_req = 1; #1;
    chk("R8 unlocked write", wr_en, 1);
    wr_req = 0;
    repeat (TO) tick();
    chk("R8 left to SAFE", state, 2);
    wr_req = 1; #1; chk("R8 blocked in SAFE", wr_en, 0); wr_req = 0;
    safe_exit = 1; tick(); safe_exit = 0;
    wr_req = 1; #1; chk("R8 relocked on re-entry", wr_en, 0); wr_req = 0;
  endtask

  task automatic t_priority();
    do_reset(); enter_diag();
    wd_th = 4'd2;
    fail_evt = 1; tick(); tick(); fail_evt = 0;
    mask_cmd = 1; tick(); mask_cmd = 0;
    clr_wake = 1; tick(); clr_wake = 0;
    chk("R10 wake beats escape", state, 3);
    do_reset(); enter_diag();
    repeat (TO-1) tick();
    go_active = 1; tick(); go_active = 0;
    chk("R10 timeout beats go_active", state, 2);
  endtask

  task automatic t_active();
    do_reset(); enter_diag();
    go_active = 1; tick(); go_active = 0;
    chk("R11 enter ACTIVE", state, 4);
    repeat (TO+5) tick();
    chk("R11 no timeout in ACTIVE", state, 4);
    clr_wake = 1; tick(); clr_wake = 0;
    chk("R5 ACTIVE wake clear to OFF", state, 3);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_timeout();
    t_lock_safe();
    t_wake();
    t_mask_escape();
    t_no_escape();
    t_cfg();
    t_priority();
    t_active();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule